// File: doc/BRIEF.md
# Threshold Trigger and Capture Window

The block watches a stream of signed ADC samples, one per clock, and chooses which of them form a recorded packet. A comparator against a programmable threshold produces a trigger in one of two styles. In edge style it fires once, on a crossing of the threshold. In level style it holds for every sample that sits on the chosen side of the threshold. A source mask can OR the comparator with external trigger lines. A gate mask can make every trigger wait until the selected gate inputs are all high.

Each accepted trigger opens a packet with three parts. The first part is a programmable number of samples from before the trigger, taken from an internal delay line. The second part is the trigger window. The third part is a postcursor whose length is counted from the first sample on which the condition is false. With retriggering enabled, a trigger that arrives during the postcursor extends the current packet. The output carries the delayed sample, a valid flag and one-cycle start and end markers. Triggering can run continuously. It can also be armed for a fixed number of packets, after which it stops.

Top module: `trig_capture`

## Requirements
- R1: After reset, out_vld, out_sop and out_eop are all low, and they stay low until a trigger is accepted.
- R2: A sample is "above" when, as a signed value, it is strictly greater than thr_lvl. Otherwise it is "below". In edge style (trg_edge=1) with trg_rise=1, the comparator fires on a sample that is above when the previous sample was below. With trg_rise=0 it fires on a sample that is below when the previous sample was above. The trigger window is then exactly that one sample.
- R3: In level style (trg_edge=0), the comparator condition holds on every sample that is above (trg_rise=1) or below (trg_rise=0). The window spans every consecutive sample on which the gated trigger holds.
- R4: The postcursor covers post_cyc samples, starting with the first sample after the window, which is the first sample on which the condition is false. In level style a post_cyc of 0 is treated as 1.
- R5: Each packet begins with pre_cyc samples from before the window. pre_cyc may be anything from 0 to MAX_PRE. For every sample, out_samp shows the input from pre_cyc+1 clocks earlier.
- R6: With retrig_en=1, a trigger during the postcursor restarts the postcursor within the same packet. With retrig_en=0 such triggers are ignored and the packet ends after the first postcursor.
- R7: src_sel bit 0 admits the comparator. Bit k (k>=1) admits ext_trg[k-1], which counts as a trigger on every cycle it is high. A source whose bit is clear never starts or extends a packet.
- R8: A trigger is accepted only while every gate_lvl bit selected by gate_sel is high.
- R9: While chan_en=1 every trigger in idle starts a packet. While chan_en=0, a one-cycle shot_go in idle arms exactly shot_num packets. After those packets, triggers are ignored.
- R10: out_sop marks the first sample of a packet and out_eop marks the last, each for one cycle. out_vld is high without a gap from start to end. A packet of one sample raises both markers together, and packets may follow one another in adjacent cycles.
- R11: Configuration (thr_lvl, trg_edge, trg_rise, retrig_en, pre_cyc, post_cyc, src_sel, gate_sel) is captured only while no packet is in progress, and takes effect one cycle after capture. A change made during a packet does not alter that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_in | input | SW | Signed input sample |
| thr_lvl | input | SW | Signed comparator threshold |
| trg_edge | input | 1 | 1 selects edge style, 0 selects level style |
| trg_rise | input | 1 | Selects rising/above (1) or falling/below (0) |
| retrig_en | input | 1 | Allows triggers during the postcursor to extend the packet |
| pre_cyc | input | PRE_W | Precursor length in samples |
| post_cyc | input | LEN_W | Postcursor length in samples |
| src_sel | input | N_EXT+1 | Source mask: bit 0 is the comparator, upper bits are the external lines |
| gate_sel | input | N_GATE | Mask of gates that must be open |
| ext_trg | input | N_EXT | External trigger lines |
| gate_lvl | input | N_GATE | Gate inputs, high means open |
| chan_en | input | 1 | Continuous triggering enable |
| shot_go | input | 1 | Arms a single-shot run of shot_num packets |
| shot_num | input | SHOT_W | Number of packets in a single-shot run |
| out_samp | output | SW | Delayed sample |
| out_vld | output | 1 | Sample belongs to a packet |
| out_sop | output | 1 | First sample of a packet |
| out_eop | output | 1 | Last sample of a packet |

## Verification
Every packet is checked against the samples the bench drove, so any slip between the framing and the delay line shows up. An off-by-one precursor or postcursor also shows up, as a shifted or lost sample, at zero and at full precursor. The bench holds a trigger during the postcursor with and without retrigger. A design that handled this wrongly would merge or split packets. The bench also drives a second crossing two cycles after a one-sample packet; a design that kept the first packet open would miss it. Triggers are also placed on masked sources, on closed gates and after the single-shot count is spent. Any packet that appeared there would reach the bench with nothing expected. Level style with a zero postcursor and zero precursor is run as well. A design lacking the one-sample floor would have to end the packet before it knew the window was over. Finally, a postcursor change made in the middle of a packet must leave that packet's length as it was.

// File: rtl/cap_pkg.sv
// Shared types for the trigger and capture block.
// Assumes: nothing beyond IEEE 1800-2017.
package cap_pkg;

    // Packet framing phase, as seen on the input timeline.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for an accepted trigger
        ST_WIN  = 2'd1,   // level window still holding
        ST_POST = 2'd2,   // counting postcursor samples
        ST_TAIL = 2'd3    // draining precursor lag to the output
    } frame_st_e;

endpackage

// File: rtl/trig_cond.sv
// Trigger condition: compares the sample with the threshold in edge or level
// style, ORs in masked external lines and qualifies by the gate mask.
// Assumes: configuration inputs are stable registers; output is combinational.
module trig_cond #(
    parameter int SW     = 16,
    parameter int N_EXT  = 2,
    parameter int N_GATE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW-1:0]     samp,
    input  logic [SW-1:0]     thr,
    input  logic              edge_mode,
    input  logic              rise,
    input  logic [N_EXT:0]    src_mask,
    input  logic [N_GATE-1:0] gate_mask,
    input  logic [N_EXT-1:0]  ext_trg,
    input  logic [N_GATE-1:0] gate_lvl,
    output logic              hit
);

    logic           above;
    logic           prev_above;
    logic           hist_vld;
    logic           self_hit;
    logic [N_EXT:0] src_vec;
    logic           gate_ok;

    // Side of the threshold for the current sample.
    assign above = $signed(samp) > $signed(thr);

    // Remember the side of the previous sample for crossing detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_above <= 1'b0;
            hist_vld   <= 1'b0;
        end else begin
            prev_above <= above;
            hist_vld   <= 1'b1;
        end
    end

    // Own comparator hit for the selected style and direction.
    always_comb begin
        if (edge_mode) begin
            if (rise) self_hit = hist_vld && above && !prev_above;
            else      self_hit = hist_vld && !above && prev_above;
        end else begin
            self_hit = rise ? above : !above;
        end
    end

    // Merge sources and apply the gate qualification.
    assign src_vec = {ext_trg, self_hit};
    assign gate_ok = &(gate_lvl | ~gate_mask);
    assign hit     = (|(src_vec & src_mask)) && gate_ok;

    // An edge-style comparator-only hit needs a change of side.
    AST_EDGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && src_mask == {{N_EXT{1'b0}}, 1'b1} && hit) |-> (above != prev_above)); // R2

endmodule

// File: rtl/pre_delay.sv
// Precursor delay line: a shift register of MAX_PRE+1 stages whose selected
// tap gives the sample from pre_sel+1 clocks earlier.
// Assumes: pre_sel never exceeds MAX_PRE (clamped by the parent).
module pre_delay #(
    parameter int SW      = 16,
    parameter int MAX_PRE = 15,
    localparam int DEPTH  = MAX_PRE + 1,
    localparam int PRE_W  = $clog2(MAX_PRE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SW-1:0]    din,
    input  logic [PRE_W-1:0] pre_sel,
    output logic [SW-1:0]    dout
);

    logic [SW-1:0] stage [DEPTH];
    logic          run_q;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            // One register stage of the delay line.
            always_ff @(posedge clk) begin
                if (!rst_n)      stage[g] <= '0;
                else if (g == 0) stage[g] <= din;
                else             stage[g] <= stage[g-1];
            end
        end
    endgenerate

    // Marks the cycles after the first post-reset edge.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    // Tap selection.
    assign dout = stage[pre_sel];

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pre_sel) <= MAX_PRE); // R5
    AST_ZERO_PRE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && pre_sel == '0) |-> (dout == $past(din))); // R5

endmodule

// File: rtl/cap_frame.sv
// Packet framing: a state machine tracks window, postcursor and precursor
// drain, and registers valid and the start and end markers. It also holds
// the single-shot packet budget.
// Assumes: configuration inputs are held while not idle (cfg_ld low).
module cap_frame
    import cap_pkg::*;
#(
    parameter int PRE_W  = 4,
    parameter int LEN_W  = 8,
    parameter int SHOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              edge_mode,
    input  logic              retrig,
    input  logic [PRE_W-1:0]  pre_len,
    input  logic [LEN_W-1:0]  post_len,
    input  logic              chan_en,
    input  logic              shot_go,
    input  logic [SHOT_W-1:0] shot_num,
    output logic              cfg_ld,
    output logic              out_vld,
    output logic              out_sop,
    output logic              out_eop
);

    frame_st_e         st_q, st_n;
    logic [LEN_W-1:0]  pcnt_q, pcnt_n;
    logic [PRE_W-1:0]  tcnt_q, tcnt_n;
    logic [SHOT_W-1:0] shots_q;
    logic              vld_n, sop_n, eop_n;
    logic              armed, start, fin;
    logic [LEN_W-1:0]  post_eff;

    // Trigger acceptance from idle.
    assign armed  = chan_en || (shots_q != '0);
    assign start  = (st_q == ST_IDLE) && armed && hit;
    assign cfg_ld = (st_q == ST_IDLE) && !start;

    // Level style never runs a zero-length postcursor.
    assign post_eff = (!edge_mode && post_len == '0) ? LEN_W'(1) : post_len;

    // Next-state and marker decisions for the current input sample.
    always_comb begin
        st_n   = st_q;
        pcnt_n = pcnt_q;
        tcnt_n = tcnt_q;
        vld_n  = 1'b0;
        sop_n  = 1'b0;
        eop_n  = 1'b0;
        fin    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    vld_n = 1'b1;
                    sop_n = 1'b1;
                    if (!edge_mode)          st_n = ST_WIN;
                    else if (post_len == '0) fin  = 1'b1;
                    else begin
                        st_n   = ST_POST;
                        pcnt_n = post_len;
                    end
                end
            end
            ST_WIN: begin
                vld_n = 1'b1;
                if (!hit) begin
                    if (post_eff == LEN_W'(1)) fin = 1'b1;
                    else begin
                        st_n   = ST_POST;
                        pcnt_n = post_eff - LEN_W'(1);
                    end
                end
            end
            ST_POST: begin
                vld_n = 1'b1;
                if (retrig && hit) begin
                    if (!edge_mode)          st_n   = ST_WIN;
                    else if (post_len == '0) fin    = 1'b1;
                    else                     pcnt_n = post_len;
                end else if (pcnt_q == LEN_W'(1)) begin
                    fin = 1'b1;
                end else begin
                    pcnt_n = pcnt_q - LEN_W'(1);
                end
            end
            ST_TAIL: begin
                vld_n = 1'b1;
                if (tcnt_q == PRE_W'(1)) begin
                    eop_n = 1'b1;
                    st_n  = ST_IDLE;
                end else begin
                    tcnt_n = tcnt_q - PRE_W'(1);
                end
            end
            default: st_n = ST_IDLE;
        endcase
        if (fin) begin
            if (pre_len == '0) begin
                eop_n = 1'b1;
                st_n  = ST_IDLE;
            end else begin
                st_n   = ST_TAIL;
                tcnt_n = pre_len;
            end
        end
    end

    // State, counters and registered output markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            pcnt_q  <= '0;
            tcnt_q  <= '0;
            out_vld <= 1'b0;
            out_sop <= 1'b0;
            out_eop <= 1'b0;
        end else begin
            st_q    <= st_n;
            pcnt_q  <= pcnt_n;
            tcnt_q  <= tcnt_n;
            out_vld <= vld_n;
            out_sop <= sop_n;
            out_eop <= eop_n;
        end
    end

    // Single-shot budget: load in idle, spend one per packet when not enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 shots_q <= '0;
        else if (shot_go && st_q == ST_IDLE)        shots_q <= shot_num;
        else if (start && !chan_en && shots_q != '0) shots_q <= shots_q - SHOT_W'(1);
    end

    AST_EDGE_NO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        edge_mode |-> (st_q != ST_WIN)); // R2
    AST_POST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_POST) |-> (pcnt_q != '0 && pcnt_q <= post_eff)); // R4
    AST_TAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TAIL) |-> (tcnt_q != '0 && tcnt_q <= pre_len)); // R5
    AST_NO_START_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !chan_en && shots_q == '0) |=> !out_sop); // R9
    AST_SOP_IN_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_vld); // R10
    AST_EOP_IN_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        out_eop |-> out_vld); // R10
    AST_VLD_ENDS_AT_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_vld) |-> $past(out_eop)); // R10
    AST_PKT_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_sop) |-> ($past(out_vld) && !$past(out_eop))); // R10

endmodule

// File: rtl/trig_capture.sv
// Top of the threshold trigger and capture window. It snapshots the
// configuration while idle and ties together the condition logic, the
// framing state machine and the precursor delay line.
// Assumes: one sample per clock; synchronous active-low reset.
module trig_capture #(
    parameter int SW      = 16,
    parameter int MAX_PRE = 15,
    parameter int LEN_W   = 8,
    parameter int N_EXT   = 2,
    parameter int N_GATE  = 2,
    parameter int SHOT_W  = 4,
    localparam int PRE_W  = $clog2(MAX_PRE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW-1:0]     samp_in,
    input  logic [SW-1:0]     thr_lvl,
    input  logic              trg_edge,
    input  logic              trg_rise,
    input  logic              retrig_en,
    input  logic [PRE_W-1:0]  pre_cyc,
    input  logic [LEN_W-1:0]  post_cyc,
    input  logic [N_EXT:0]    src_sel,
    input  logic [N_GATE-1:0] gate_sel,
    input  logic [N_EXT-1:0]  ext_trg,
    input  logic [N_GATE-1:0] gate_lvl,
    input  logic              chan_en,
    input  logic              shot_go,
    input  logic [SHOT_W-1:0] shot_num,
    output logic [SW-1:0]     out_samp,
    output logic              out_vld,
    output logic              out_sop,
    output logic              out_eop
);

    logic [SW-1:0]     thr_q;
    logic              edge_q, rise_q, retrig_q;
    logic [PRE_W-1:0]  pre_q, pre_clamp;
    logic [LEN_W-1:0]  post_q;
    logic [N_EXT:0]    src_q;
    logic [N_GATE-1:0] gate_q;
    logic              cfg_ld;
    logic              hit;

    // Keep the precursor inside the delay line.
    assign pre_clamp = (int'(pre_cyc) > MAX_PRE) ? PRE_W'(MAX_PRE) : pre_cyc;

    // Configuration snapshot, refreshed only between packets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q    <= '0;
            edge_q   <= 1'b1;
            rise_q   <= 1'b1;
            retrig_q <= 1'b0;
            pre_q    <= '0;
            post_q   <= '0;
            src_q    <= '0;
            gate_q   <= '0;
        end else if (cfg_ld) begin
            thr_q    <= thr_lvl;
            edge_q   <= trg_edge;
            rise_q   <= trg_rise;
            retrig_q <= retrig_en;
            pre_q    <= pre_clamp;
            post_q   <= post_cyc;
            src_q    <= src_sel;
            gate_q   <= gate_sel;
        end
    end

    trig_cond #(
        .SW     (SW),
        .N_EXT  (N_EXT),
        .N_GATE (N_GATE)
    ) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp      (samp_in),
        .thr       (thr_q),
        .edge_mode (edge_q),
        .rise      (rise_q),
        .src_mask  (src_q),
        .gate_mask (gate_q),
        .ext_trg   (ext_trg),
        .gate_lvl  (gate_lvl),
        .hit       (hit)
    );

    cap_frame #(
        .PRE_W  (PRE_W),
        .LEN_W  (LEN_W),
        .SHOT_W (SHOT_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .edge_mode (edge_q),
        .retrig    (retrig_q),
        .pre_len   (pre_q),
        .post_len  (post_q),
        .chan_en   (chan_en),
        .shot_go   (shot_go),
        .shot_num  (shot_num),
        .cfg_ld    (cfg_ld),
        .out_vld   (out_vld),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );

    pre_delay #(
        .SW      (SW),
        .MAX_PRE (MAX_PRE)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (samp_in),
        .pre_sel (pre_q),
        .dout    (out_samp)
    );

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_eop) |=> $stable(post_q)); // R11

endmodule

// File: tb/test_trig_capture.sv
// Scoreboard bench: tests push expected packet samples into a queue, the
// monitor pops and compares whenever the design presents a valid sample.
module test_trig_capture;

    localparam int CLK_PERIOD = 10;
    localparam int SW      = 16;
    localparam int MAX_PRE = 15;
    localparam int LEN_W   = 8;
    localparam int N_EXT   = 2;
    localparam int N_GATE  = 2;
    localparam int SHOT_W  = 4;
    localparam int PRE_W   = $clog2(MAX_PRE + 1);
    localparam int WD_LIMIT = 50000;

    typedef struct packed {
        logic [SW-1:0] d;
        logic          s;
        logic          e;
    } exp_t;

    logic              clk;
    logic              rst_n;
    logic [SW-1:0]     samp_in;
    logic [SW-1:0]     thr_lvl;
    logic              trg_edge, trg_rise, retrig_en;
    logic [PRE_W-1:0]  pre_cyc;
    logic [LEN_W-1:0]  post_cyc;
    logic [N_EXT:0]    src_sel;
    logic [N_GATE-1:0] gate_sel;
    logic [N_EXT-1:0]  ext_trg;
    logic [N_GATE-1:0] gate_lvl;
    logic              chan_en, shot_go;
    logic [SHOT_W-1:0] shot_num;
    logic [SW-1:0]     out_samp;
    logic              out_vld, out_sop, out_eop;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;
    string cur_tag = "R1";
    exp_t  exp_q [$];
    string tag_q [$];

    logic [SW-1:0]     wave   [64];
    logic [N_EXT-1:0]  ext_w  [64];
    logic [N_GATE-1:0] gate_w [64];
    logic [SW-1:0]     idle_val;
    int                chg_at;
    logic [LEN_W-1:0]  chg_val;

    trig_capture #(
        .SW(SW), .MAX_PRE(MAX_PRE), .LEN_W(LEN_W),
        .N_EXT(N_EXT), .N_GATE(N_GATE), .SHOT_W(SHOT_W)
    ) i_trig_capture (
        .clk(clk), .rst_n(rst_n), .samp_in(samp_in), .thr_lvl(thr_lvl),
        .trg_edge(trg_edge), .trg_rise(trg_rise), .retrig_en(retrig_en),
        .pre_cyc(pre_cyc), .post_cyc(post_cyc), .src_sel(src_sel),
        .gate_sel(gate_sel), .ext_trg(ext_trg), .gate_lvl(gate_lvl),
        .chan_en(chan_en), .shot_go(shot_go), .shot_num(shot_num),
        .out_samp(out_samp), .out_vld(out_vld), .out_sop(out_sop),
        .out_eop(out_eop)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: an overlong run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            done = 1;
            check(0, cur_tag, "watchdog expired", cyc, WD_LIMIT);
            finish_up();
        end
    end

    // Monitor: compare every valid output sample with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (exp_q.size() == 0) begin
                check(0, cur_tag, "unexpected sample", int'($signed(out_samp)), 0);
            end else begin
                exp_t  it;
                string t;
                it = exp_q.pop_front();
                t  = tag_q.pop_front();
                check(out_samp == it.d, t, "data", int'($signed(out_samp)), int'($signed(it.d)));
                check(out_sop == it.s, t, "sop", int'(out_sop), int'(it.s));
                check(out_eop == it.e, t, "eop", int'(out_eop), int'(it.e));
            end
        end else if (rst_n && (out_sop || out_eop)) begin
            check(0, "R10", "marker without valid", int'({out_sop, out_eop}), 0);
        end
    end

    task automatic push_range(input int a, input int b, input string tag);
        for (int k = a; k <= b; k++) begin
            exp_t it;
            it.d = wave[k];
            it.s = (k == a);
            it.e = (k == b);
            exp_q.push_back(it);
            tag_q.push_back(tag);
        end
    endtask

    // Baseline wave: distinct values below (low=1) or above zero.
    task automatic base_wave(input bit low);
        for (int i = 0; i < 64; i++) begin
            wave[i]   = low ? SW'(-100 - i) : SW'(100 + i);
            ext_w[i]  = '0;
            gate_w[i] = '0;
        end
    endtask

    task automatic set_cfg(input bit e, input bit r, input bit rt, input int pre,
                           input int post, input int src, input int gm, input int idle);
        @(negedge clk);
        src_sel = '0;
        repeat (2) @(negedge clk);
        trg_edge  = e;
        trg_rise  = r;
        retrig_en = rt;
        pre_cyc   = PRE_W'(pre);
        post_cyc  = LEN_W'(post);
        gate_sel  = N_GATE'(gm);
        idle_val  = SW'(idle);
        samp_in   = idle_val;
        ext_trg   = '0;
        gate_lvl  = '0;
        repeat (3) @(negedge clk);
        src_sel = (N_EXT+1)'(src);
        repeat (3) @(negedge clk);
    endtask

    task automatic play(input int n, input string tag);
        cur_tag = tag;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            samp_in  = wave[i];
            ext_trg  = ext_w[i];
            gate_lvl = gate_w[i];
            if (i == chg_at) post_cyc = chg_val;
        end
        @(negedge clk);
        samp_in  = idle_val;
        ext_trg  = '0;
        gate_lvl = '0;
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, tag, "samples never delivered", exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
        chg_at = -1;
    endtask

    initial begin
        rst_n = 0; samp_in = '0; thr_lvl = '0; trg_edge = 1; trg_rise = 1;
        retrig_en = 0; pre_cyc = '0; post_cyc = '0; src_sel = '0; gate_sel = '0;
        ext_trg = '0; gate_lvl = '0; chan_en = 1; shot_go = 0; shot_num = '0;
        idle_val = SW'(-1); chg_at = -1; chg_val = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: quiet after reset
        check(!out_vld && !out_sop && !out_eop, "R1", "outputs after reset",
              int'({out_vld, out_sop, out_eop}), 0);

        // R2/R4/R5: rising edge, pre 2, post 3
        set_cfg(1, 1, 0, 2, 3, 1, 0, -1);
        base_wave(1);
        for (int i = 10; i <= 12; i++) wave[i] = SW'(1000 + i);
        push_range(8, 13, "R2");
        play(30, "R2");

        // R2: falling edge, pre 1, post 2
        set_cfg(1, 0, 0, 1, 2, 1, 0, -1);
        base_wave(1);
        for (int i = 10; i <= 12; i++) wave[i] = SW'(1000 + i);
        push_range(12, 15, "R2");
        play(30, "R2");

        // R3/R4: level above, pre 2, post 2
        set_cfg(0, 1, 0, 2, 2, 1, 0, -1);
        base_wave(1);
        for (int i = 10; i <= 13; i++) wave[i] = SW'(1000 + i);
        push_range(8, 15, "R3");
        play(30, "R3");

        // R4: level below with zero pre and zero post (post floor of one)
        set_cfg(0, 0, 0, 0, 0, 1, 0, 500);
        base_wave(0);
        for (int i = 10; i <= 11; i++) wave[i] = SW'(-300 - i);
        push_range(10, 12, "R4");
        play(30, "R4");

        // R6: retrigger extends the packet
        set_cfg(1, 1, 1, 1, 4, 1, 0, -1);
        base_wave(1);
        wave[10] = SW'(1010);
        wave[13] = SW'(1013);
        push_range(9, 17, "R6");
        play(30, "R6");

        // R6: without retrigger the second crossing is ignored
        set_cfg(1, 1, 0, 1, 4, 1, 0, -1);
        base_wave(1);
        wave[10] = SW'(1010);
        wave[13] = SW'(1013);
        push_range(9, 14, "R6");
        play(30, "R6");

        // R7: only external line 0 admitted; comparator crossing ignored
        set_cfg(1, 1, 0, 1, 1, 2, 0, -1);
        base_wave(1);
        wave[5] = SW'(1005);
        ext_w[12] = 2'b01;
        ext_w[20] = 2'b10;
        push_range(11, 13, "R7");
        play(30, "R7");

        // R8: crossing while gate 0 closed is ignored, open one accepted
        set_cfg(1, 1, 0, 0, 1, 1, 1, -1);
        base_wave(1);
        wave[5]  = SW'(1005);
        wave[15] = SW'(1015);
        for (int i = 10; i < 30; i++) gate_w[i] = 2'b01;
        push_range(15, 16, "R8");
        play(30, "R8");

        // R9: single shot of two packets, third crossing ignored
        chan_en = 0;
        set_cfg(1, 1, 0, 0, 1, 1, 0, -1);
        @(negedge clk);
        shot_num = SHOT_W'(2);
        shot_go  = 1;
        @(negedge clk);
        shot_go  = 0;
        base_wave(1);
        wave[5]  = SW'(1005);
        wave[15] = SW'(1015);
        wave[25] = SW'(1025);
        push_range(5, 6, "R9");
        push_range(15, 16, "R9");
        play(35, "R9");
        chan_en = 1;

        // R5: full precursor
        set_cfg(1, 1, 0, MAX_PRE, 0, 1, 0, -1);
        base_wave(1);
        wave[20] = SW'(1020);
        push_range(20 - MAX_PRE, 20, "R5");
        play(30, "R5");

        // R10: one-sample packets two cycles apart
        set_cfg(1, 1, 0, 0, 0, 1, 0, -1);
        base_wave(1);
        wave[30] = SW'(1030);
        wave[32] = SW'(1032);
        push_range(30, 30, "R10");
        push_range(32, 32, "R10");
        play(40, "R10");

        // R11: postcursor change during a packet has no effect on it
        set_cfg(0, 1, 0, 0, 3, 1, 0, -1);
        base_wave(1);
        wave[10] = SW'(1010);
        wave[11] = SW'(1011);
        chg_at  = 11;
        chg_val = '0;
        push_range(10, 14, "R11");
        play(30, "R11");

        done = 1;
        finish_up();
    end

endmodule